// File: doc/BRIEF.md
# JTAG Test Access Port with LED User Register

This block is a JTAG test access port that gives a host a simple byte-wide mailbox into the chip. A 6-bit instruction register selects which data register sits between TDI and TDO. One opcode, 0x02, selects an 8-bit user register. Every other opcode selects a 1-bit bypass register. Each bit of the user register drives one LED output directly and continuously.

A host writes a byte in two scans. An instruction scan first loads 0x02. A data scan then shifts the eight new bits in, least significant bit first. While the new byte enters at the most significant end, the byte that was there leaves from the least significant end on TDO. The host therefore gets back the previous contents in the same scan. Nothing latches the LEDs separately, so they track the register bit by bit while the scan is in progress.

Top module: `jtag_led_tap`

## Requirements
- R1: While `trstN` is low, `ledOut` is 0x00, `tdoEnable` is 0, `tdo` is 0, and the instruction register holds the bypass opcode 6'b111111.
- R2: Five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. The instruction then reverts to bypass, and the user register keeps its contents.
- R3: The instruction register is 6 bits wide and is shifted in least significant bit first. Capture-IR loads 6'b000001, which is returned on `tdo` during Shift-IR with bit 0 first.
- R4: The instruction in force changes only on the edge that leaves Update-IR (or in Test-Logic-Reset). It stays in force across any number of later data scans.
- R5: With opcode 0x02 in force, Shift-DR moves `tdi` into bit 7 of the 8-bit user register and puts bit 0 on `tdo`. An 8-bit scan therefore returns the previous byte, least significant bit first.
- R6: The user register changes only in Shift-DR while opcode 0x02 is in force. Capture-DR and Update-DR leave it unchanged, so each scan reads back exactly what the previous scan wrote.
- R7: `ledOut[i]` equals bit i of the user register at all times, including partway through a data scan.
- R8: Any opcode other than 0x02 selects a 1-bit bypass register. It captures 0 in Capture-DR and delays `tdi` by one `tck` in Shift-DR. The user register and `ledOut` are left unchanged.
- R9: `tdo` and `tdoEnable` change on the falling edge of `tck`. `tdoEnable` is 1 only while the controller is in Shift-IR or Shift-DR. Elsewhere `tdo` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge of `tck` |
| tdi | input | 1 | Serial data in, sampled on the rising edge of `tck` |
| tdo | output | 1 | Serial data out, updated on the falling edge of `tck` |
| tdoEnable | output | 1 | High while `tdo` carries shift data |
| ledOut | output | 8 | Live copy of the user register |

## Verification
A `tdo` bit is due at the falling edge that follows the rising edge entering, or staying in, a shift state. The bench therefore samples `tdo` and `tdoEnable` one nanosecond after each falling edge, before it changes `tms` and `tdi` for the next rising edge. The user register and `ledOut` change on the rising edge that consumes a bit in Shift-DR. The mid-scan LED check is read after four shift edges, and the final LED value is read after the scan has returned to Run-Test/Idle. An opcode takes effect on the rising edge that leaves Update-IR, so the first data scan that relies on it begins on the next cycle.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tapState_t;

  typedef struct packed {
    logic resetLogic;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
  } tapStrobes_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  output tapStrobes_t strobes
);

  tapState_t state;
  tapState_t nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      S_RESET:  nextState = tms ? S_RESET  : S_IDLE;
      S_IDLE:   nextState = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: nextState = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nextState = tms ? S_EX1_DR : S_SHF_DR;
      S_SHF_DR: nextState = tms ? S_EX1_DR : S_SHF_DR;
      S_EX1_DR: nextState = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nextState = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nextState = tms ? S_UPD_DR : S_SHF_DR;
      S_UPD_DR: nextState = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: nextState = tms ? S_RESET  : S_CAP_IR;
      S_CAP_IR: nextState = tms ? S_EX1_IR : S_SHF_IR;
      S_SHF_IR: nextState = tms ? S_EX1_IR : S_SHF_IR;
      S_EX1_IR: nextState = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nextState = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nextState = tms ? S_UPD_IR : S_SHF_IR;
      S_UPD_IR: nextState = tms ? S_SEL_DR : S_IDLE;
      default:  nextState = S_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= S_RESET;
    else        state <= nextState;
  end

  always_comb begin
    strobes.resetLogic = (state == S_RESET);
    strobes.captureIr  = (state == S_CAP_IR);
    strobes.shiftIr    = (state == S_SHF_IR);
    strobes.updateIr   = (state == S_UPD_IR);
    strobes.captureDr  = (state == S_CAP_DR);
    strobes.shiftDr    = (state == S_SHF_DR);
  end

  // Checker-side run counter of consecutive TMS-high edges (saturates at 5).
  logic [2:0] tmsHighRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)    tmsHighRun <= '0;
    else if (!tms) tmsHighRun <= '0;
    else if (tmsHighRun != 3'd5) tmsHighRun <= tmsHighRun + 3'd1;
  end

  p_tms_reset_r2: assert property (@(posedge tck) disable iff (!trstN)
    (tms && tmsHighRun >= 3'd4) |=> (state == S_RESET));

  p_capture_ir_path_r3: assert property (@(posedge tck) disable iff (!trstN)
    (state == S_CAP_IR) |=> (state == S_SHF_IR || state == S_EX1_IR));

  p_single_strobe_r9: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({strobes.shiftIr, strobes.shiftDr, strobes.captureDr, strobes.captureIr}));

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_pkg::*;
#(
  parameter int          IR_W       = 6,
  parameter int          DR_W       = 8,
  parameter logic [IR_W-1:0] USER_OP    = 6'h02,
  parameter logic [IR_W-1:0] IR_CAPTURE = 6'b000001
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  tapStrobes_t     strobes,
  output logic            tdo,
  output logic            tdoEnable,
  output logic [DR_W-1:0] userReg
);

  localparam logic [IR_W-1:0] BYPASS_OP = '1;

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;
  logic            bypassReg;
  logic            userSel;
  logic            shiftBit;

  assign userSel = (irReg == USER_OP);

  // Instruction shift stage and instruction register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= BYPASS_OP;
    end else begin
      if (strobes.captureIr)    irShift <= IR_CAPTURE;
      else if (strobes.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (strobes.resetLogic)     irReg <= BYPASS_OP;
      else if (strobes.updateIr)  irReg <= irShift;
    end
  end

  // User register: shifts only, never captures
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                          userReg <= '0;
    else if (strobes.shiftDr && userSel) userReg <= {tdi, userReg[DR_W-1:1]};
  end

  // Bypass register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                             bypassReg <= 1'b0;
    else if (strobes.captureDr && !userSel) bypassReg <= 1'b0;
    else if (strobes.shiftDr && !userSel)   bypassReg <= tdi;
  end

  always_comb begin
    if (strobes.shiftIr) shiftBit = irShift[0];
    else if (userSel)    shiftBit = userReg[0];
    else                 shiftBit = bypassReg;
  end

  // Output stage on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo       <= 1'b0;
      tdoEnable <= 1'b0;
    end else begin
      tdoEnable <= strobes.shiftIr || strobes.shiftDr;
      tdo       <= (strobes.shiftIr || strobes.shiftDr) ? shiftBit : 1'b0;
    end
  end

  p_ir_hold_r4: assert property (@(posedge tck) disable iff (!trstN)
    !(strobes.updateIr || strobes.resetLogic) |=> $stable(irReg));

  p_reset_opcode_r2: assert property (@(posedge tck) disable iff (!trstN)
    strobes.resetLogic |=> (irReg == BYPASS_OP));

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!trstN)
    strobes.captureIr |=> (irShift == IR_CAPTURE));

  p_user_msb_r5: assert property (@(posedge tck) disable iff (!trstN)
    (strobes.shiftDr && userSel) |=> (userReg[DR_W-1] == $past(tdi)));

  p_user_hold_r6: assert property (@(posedge tck) disable iff (!trstN)
    !(strobes.shiftDr && userSel) |=> $stable(userReg));

  p_bypass_capture_r8: assert property (@(posedge tck) disable iff (!trstN)
    (strobes.captureDr && !userSel) |=> (bypassReg == 1'b0));

endmodule

// File: rtl/jtag_led_tap.sv
module jtag_led_tap
  import tap_pkg::*;
#(
  parameter int IR_W = 6,
  parameter int DR_W = 8
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdoEnable,
  output logic [DR_W-1:0] ledOut
);

  localparam logic [IR_W-1:0] USER_OP    = IR_W'(2);
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  tapStrobes_t     strobes;
  logic [DR_W-1:0] userReg;

  tap_ctrl i_ctrl (
    .tck     (tck),
    .trstN   (trstN),
    .tms     (tms),
    .strobes (strobes)
  );

  tap_datapath #(
    .IR_W       (IR_W),
    .DR_W       (DR_W),
    .USER_OP    (USER_OP),
    .IR_CAPTURE (IR_CAPTURE)
  ) i_datapath (
    .tck       (tck),
    .trstN     (trstN),
    .tdi       (tdi),
    .strobes   (strobes),
    .tdo       (tdo),
    .tdoEnable (tdoEnable),
    .userReg   (userReg)
  );

  assign ledOut = userReg;

endmodule

// File: tb/test_jtag_led_tap.sv
`timescale 1ns/1ps
module test_jtag_led_tap;

  logic       tck = 1'b0;
  logic       trstN = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       tdo;
  logic       tdoEnable;
  logic [7:0] ledOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;
  logic       shiftEnOk;
  logic       idleEnOk;

  always #2 tck = ~tck;

  jtag_led_tap i_jtag_led_tap (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoEnable(tdoEnable), .ledOut(ledOut)
  );

  // {written byte, expected readout}
  localparam logic [15:0] VECS [6] = '{
    16'h93_00, 16'hA1_93, 16'hFF_A1, 16'h00_FF, 16'h5A_00, 16'hC3_5A
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One TCK cycle: sample outputs just after falling edge, then drive inputs
  task automatic step(input logic m, input logic d, output logic o, output logic en);
    @(negedge tck); #1;
    o = tdo; en = tdoEnable;
    tms = m; tdi = d;
  endtask

  task automatic irScan(input logic [5:0] op, output logic [5:0] cap);
    logic o, en;
    step(1, 0, o, en); step(1, 0, o, en); step(0, 0, o, en); step(0, 0, o, en);
    idleEnOk = !en && !o;
    shiftEnOk = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(i == 5, op[i], o, en);
      cap[i] = o;
      shiftEnOk &= en;
    end
    step(1, 0, o, en); step(0, 0, o, en);
  endtask

  task automatic drScan(input logic [7:0] d, input logic userOn, output logic [7:0] q);
    logic o, en;
    step(1, 0, o, en); step(0, 0, o, en); step(0, 0, o, en);
    shiftEnOk = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(i == 7, d[i], o, en);
      q[i] = o;
      shiftEnOk &= en;
      if (i == 4 && userOn)  // R7: live mirror after four shift edges
        check("R7 mid-scan", ledOut, {d[3:0], model[7:4]});
    end
    step(1, 0, o, en); step(0, 0, o, en);
    if (userOn) model = d;
  endtask

  logic [5:0] cap;
  logic [7:0] q;
  logic       o, en;
  bit         timedOut = 0;

  initial begin
    #150000;
    timedOut = 1;
  end

  initial begin
    // R1: reset state
    #5;
    check("R1 led", ledOut, 8'h00);
    check("R1 tdo/en", {6'b0, tdo, tdoEnable}, 8'h00);
    @(negedge tck); #1; trstN = 1'b1; tms = 1'b1;
    step(1, 0, o, en); step(0, 0, o, en);

    // R8: after reset the IR is bypass: one-cycle delay, first bit 0
    drScan(8'hB5, 1'b0, q);
    check("R8 bypass after reset (R1)", q, 8'h6A);
    check("R8 led unchanged", ledOut, 8'h00);

    // R3: capture pattern; R9: enable during shift, idle elsewhere
    irScan(6'h02, cap);
    check("R3 IR capture", {2'b0, cap}, 8'h01);
    check("R9 tdoEnable in Shift-IR", {7'b0, shiftEnOk}, 8'h01);
    check("R9 idle tdo/en", {7'b0, idleEnOk}, 8'h01);

    // R5/R6/R4: vector walk through user register
    for (int v = 0; v < 6; v++) begin
      drScan(VECS[v][15:8], 1'b1, q);
      check("R5 R6 readback", q, VECS[v][7:0]);
      check("R7 led after scan", ledOut, VECS[v][15:8]);
    end
    check("R4 opcode persists / R9 Shift-DR enable", {7'b0, shiftEnOk}, 8'h01);

    // R8: other opcode, user register untouched
    irScan(6'h05, cap);
    check("R3 IR capture again", {2'b0, cap}, 8'h01);
    drScan(8'h3C, 1'b0, q);
    check("R8 bypass delay", q, 8'h78);
    check("R8 led kept", ledOut, model);

    // R2: five TMS-high cycles from Shift-DR of the user register
    irScan(6'h02, cap);
    step(1, 0, o, en); step(0, 0, o, en); step(0, 0, o, en);
    step(1, 0, o, en);            // edge shifts one 0 bit in, leaves Shift-DR
    model = {1'b0, model[7:1]};
    for (int i = 0; i < 4; i++) step(1, 0, o, en);
    step(0, 0, o, en);            // to Run-Test/Idle
    check("R2 led kept through TMS reset", ledOut, model);
    drScan(8'h81, 1'b0, q);
    check("R2 opcode reverted to bypass", q, 8'h02);
    check("R2 led after bypass scan", ledOut, model);

    // R1: asynchronous reset clears register and LEDs
    #1 trstN = 1'b0; #1;
    check("R1 async reset led", ledOut, 8'h00);
    check("R1 async reset en", {7'b0, tdoEnable}, 8'h00);
    finish();
  end

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge timedOut) begin
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule